// File: doc/BRIEF.md
# Card Boot-Mode Command Line Controller

This block holds the command line of a memory-card host low while a card boots, and watches data line 0 for the card's boot status. Software arms the forced-low condition by writing a control bit. The line does not move until the next write to the command register. Clearing the bit lets the line go again and aborts any transfer still in flight.

A second control bit asks for a boot status after the next command. When that command is issued, a down-counter is loaded with a programmable number of card-clock cycles. DAT0 is then sampled on every card-clock edge. If DAT0 is seen low inside the window, the acknowledge flag is set. If the window runs out first, a sticky data-timeout flag is raised. Card protocol decoding and CRC checking are done elsewhere.

Top module: `boot_cmd_line_ctrl`

## Requirements
- R1: After reset `cmd_oe`, `abort_pulse`, `force_status`, `ack_cfg`, `boot_ack_ok` and `data_timeout` are 0, and `cmd_out` is 1. Both control bits are cleared by reset.
- R2: Writing 1 to the force bit (`cfg_wr` with `cfg_force_wdata`=1) does not drive the line by itself. `cmd_oe` stays 0 until a command write.
- R3: A `cmd_wr` while the force bit is set makes `cmd_oe`=1 and `cmd_out`=0 from the clock edge that samples it. The line stays forced until the bit is cleared.
- R4: A control write with `cfg_force_wdata`=0 releases the line: `cmd_oe`=0 and `cmd_out`=1 after that edge.
- R5: A control write that clears a set force bit while `xfer_pending`=1 produces `abort_pulse`=1 for exactly one cycle after that edge. No pulse is produced when the bit was already 0 or when no transfer is pending.
- R6: `force_status` reads 1 only after a forced line has been released by clearing the bit. A write of 1 to the force bit returns it to 0. Clearing a bit that was armed but never activated leaves it 0.
- R7: If the acknowledge bit (`cfg_ack_wdata`, read back on `ack_cfg`) is set, a `cmd_wr` loads `tmo_cycles`=N. DAT0 is then sampled on the next N+1 edges. If DAT0 is low on any of them, `boot_ack_ok` becomes 1 and no timeout is raised.
- R8: If DAT0 stays high for all N+1 samples, `data_timeout` becomes 1. It stays 1 until a cycle with `tmo_clr`=1.
- R9: A `cmd_wr` while the acknowledge bit is 0 starts no window. `data_timeout` stays 0 whatever DAT0 does.
- R10: A new acknowledged command clears `boot_ack_ok` and restarts the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_force_wdata | input | 1 | Force-low bit write value |
| cfg_ack_wdata | input | 1 | Boot-acknowledge bit write value |
| cmd_wr | input | 1 | Command register write strobe |
| xfer_pending | input | 1 | A data transfer is in progress |
| dat0_in | input | 1 | Sampled DAT0 level |
| tmo_cycles | input | TMO_W | Boot status window length minus one |
| tmo_clr | input | 1 | Write-1-to-clear for the timeout flag |
| cmd_oe | output | 1 | Command line output enable |
| cmd_out | output | 1 | Command line drive value |
| abort_pulse | output | 1 | One-cycle transfer abort |
| force_status | output | 1 | Read-back of the force bit: line released |
| ack_cfg | output | 1 | Read-back of the acknowledge bit |
| boot_ack_ok | output | 1 | Boot status seen on DAT0 |
| data_timeout | output | 1 | Sticky boot status timeout |

## Verification
The assertions check the following on every cycle:
- the line only starts being driven after a command write;
- a release write always frees the line;
- an abort is a single cycle and always caused by a release during a pending transfer;
- the timeout flag holds until it is cleared;
- an acknowledge only rises after DAT0 was low.

Only the bench's scenarios can show the rest. These are the exact window boundary (DAT0 low on sample N+1 versus N+2), the read-back meaning of the force bit across arm, activate and release sequences, and the absence of any window when acknowledge is off.

// File: rtl/boot_cmd_pkg.sv
// Package: shared types for the boot-mode command line controller.
// Assumes nothing beyond the enclosing project.
package boot_cmd_pkg;
    typedef enum logic [0:0] {
        ACK_IDLE = 1'b0,
        ACK_WAIT = 1'b1
    } ack_state_e;
endpackage

// File: rtl/bcl_ctrl_regs.sv
// Control bits: force-low arm bit, acknowledge bit, release status and abort pulse.
// Assumes line_forced comes from the command drive stage, in the same clock domain.
module bcl_ctrl_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_force_wdata,
    input  logic cfg_ack_wdata,
    input  logic xfer_pending,
    input  logic line_forced,
    output logic force_en,
    output logic ack_en,
    output logic released,
    output logic abort_pulse
);
    logic clr_force;

    // Purpose: detect a write that clears the force bit.
    always_comb clr_force = cfg_wr && !cfg_force_wdata;

    // Purpose: hold both control bits, set or cleared by control writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_en <= 1'b0;
            ack_en   <= 1'b0;
        end else if (cfg_wr) begin
            force_en <= cfg_force_wdata;
            ack_en   <= cfg_ack_wdata;
        end
    end

    // Purpose: track whether a forced line was released (force bit read-back).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            released <= 1'b0;
        end else if (cfg_wr && cfg_force_wdata) begin
            released <= 1'b0;
        end else if (clr_force && line_forced) begin
            released <= 1'b1;
        end
    end

    // Purpose: one-cycle abort when the force bit is cleared during a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_pulse <= 1'b0;
        end else begin
            abort_pulse <= clr_force && force_en && xfer_pending;
        end
    end
endmodule

// File: rtl/bcl_cmd_drive.sv
// Command line drive: forces the line low after a command write while armed.
// Assumes force_en is the registered arm bit. A release write wins over a same-cycle command.
module bcl_cmd_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic force_en,
    input  logic cfg_wr,
    input  logic cfg_force_wdata,
    input  logic cmd_wr,
    output logic line_forced,
    output logic cmd_oe,
    output logic cmd_out
);
    // Purpose: activate the forced-low state on a command write, drop it on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_forced <= 1'b0;
        end else if (cfg_wr && !cfg_force_wdata) begin
            line_forced <= 1'b0;
        end else if (cmd_wr && force_en) begin
            line_forced <= 1'b1;
        end
    end

    // Purpose: present the pad controls; the line idles high when not forced.
    always_comb begin
        cmd_oe  = line_forced;
        cmd_out = !line_forced;
    end
endmodule

// File: rtl/bcl_ack_timer.sv
// Boot status watcher: after an acknowledged command, waits for DAT0 low within a window.
// Assumes dat0_in is already synchronous to clk. A window of load value N samples N+1 edges.
module bcl_ack_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TMO_W-1:0] load,
    input  logic             dat0_in,
    input  logic             tmo_clr,
    output logic             ack_ok,
    output logic             timeout
);
    import boot_cmd_pkg::*;

    localparam logic [TMO_W-1:0] CNT_ZERO = '0;
    localparam logic [TMO_W-1:0] CNT_ONE  = {{(TMO_W-1){1'b0}}, 1'b1};

    ack_state_e       state;
    logic [TMO_W-1:0] cnt;
    logic             seen_low;
    logic             expire;

    // Purpose: classify the current sample while the window is open.
    always_comb begin
        seen_low = (state == ACK_WAIT) && !dat0_in && !start;
        expire   = (state == ACK_WAIT) && dat0_in && (cnt == CNT_ZERO) && !start;
    end

    // Purpose: run the window counter and the acknowledge flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ACK_IDLE;
            cnt    <= CNT_ZERO;
            ack_ok <= 1'b0;
        end else if (start) begin
            state  <= ACK_WAIT;
            cnt    <= load;
            ack_ok <= 1'b0;
        end else if (seen_low) begin
            state  <= ACK_IDLE;
            ack_ok <= 1'b1;
        end else if (expire) begin
            state  <= ACK_IDLE;
        end else if (state == ACK_WAIT) begin
            cnt    <= cnt - CNT_ONE;
        end
    end

    // Purpose: sticky timeout flag, cleared by write-1; setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout <= 1'b0;
        end else if (expire) begin
            timeout <= 1'b1;
        end else if (tmo_clr) begin
            timeout <= 1'b0;
        end
    end
endmodule

// File: rtl/boot_cmd_line_ctrl.sv
// Top: boot-mode command line controller. Joins the control bits, the line drive and the boot status watcher.
// Assumes every input is synchronous to the card clock.
module boot_cmd_line_ctrl #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_force_wdata,
    input  logic             cfg_ack_wdata,
    input  logic             cmd_wr,
    input  logic             xfer_pending,
    input  logic             dat0_in,
    input  logic [TMO_W-1:0] tmo_cycles,
    input  logic             tmo_clr,
    output logic             cmd_oe,
    output logic             cmd_out,
    output logic             abort_pulse,
    output logic             force_status,
    output logic             ack_cfg,
    output logic             boot_ack_ok,
    output logic             data_timeout
);
    logic force_en;
    logic ack_en;
    logic line_forced;
    logic ack_start;

    // Purpose: a command write while acknowledge is set opens the window.
    always_comb ack_start = cmd_wr && ack_en;

    bcl_ctrl_regs regs_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_wr          (cfg_wr),
        .cfg_force_wdata (cfg_force_wdata),
        .cfg_ack_wdata   (cfg_ack_wdata),
        .xfer_pending    (xfer_pending),
        .line_forced     (line_forced),
        .force_en        (force_en),
        .ack_en          (ack_en),
        .released        (force_status),
        .abort_pulse     (abort_pulse)
    );

    bcl_cmd_drive drive_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .force_en        (force_en),
        .cfg_wr          (cfg_wr),
        .cfg_force_wdata (cfg_force_wdata),
        .cmd_wr          (cmd_wr),
        .line_forced     (line_forced),
        .cmd_oe          (cmd_oe),
        .cmd_out         (cmd_out)
    );

    bcl_ack_timer #(.TMO_W(TMO_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (ack_start),
        .load    (tmo_cycles),
        .dat0_in (dat0_in),
        .tmo_clr (tmo_clr),
        .ack_ok  (boot_ack_ok),
        .timeout (data_timeout)
    );

    // Purpose: expose the acknowledge bit for read-back.
    always_comb ack_cfg = ack_en;
endmodule

// File: rtl/boot_cmd_line_ctrl_chk.sv
// Checker: temporal rules of the boot-mode command line controller, bound to the top.
// Assumes reset is held for at least one clock edge at start.
module boot_cmd_line_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_wr,
    input logic cfg_force_wdata,
    input logic cmd_wr,
    input logic xfer_pending,
    input logic dat0_in,
    input logic tmo_clr,
    input logic cmd_oe,
    input logic abort_pulse,
    input logic boot_ack_ok,
    input logic data_timeout
);
    AST_DRIVE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> $past(cmd_wr)); // R2
    AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_force_wdata) |=> !cmd_oe); // R4
    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse); // R5
    AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_pulse) |-> $past(cfg_wr && !cfg_force_wdata && xfer_pending)); // R5
    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (data_timeout && !tmo_clr) |=> data_timeout); // R8
    AST_ACK_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_ack_ok) |-> $past(!dat0_in)); // R7
endmodule

bind boot_cmd_line_ctrl boot_cmd_line_ctrl_chk chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_wr          (cfg_wr),
    .cfg_force_wdata (cfg_force_wdata),
    .cmd_wr          (cmd_wr),
    .xfer_pending    (xfer_pending),
    .dat0_in         (dat0_in),
    .tmo_clr         (tmo_clr),
    .cmd_oe          (cmd_oe),
    .abort_pulse     (abort_pulse),
    .boot_ack_ok     (boot_ack_ok),
    .data_timeout    (data_timeout)
);

// File: tb/boot_cmd_line_ctrl_tb_top.sv
// Bench: directed corner cases plus seeded random boot status windows.
module boot_cmd_line_ctrl_tb_top;
    localparam int TMO_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_wr, cfg_force_wdata, cfg_ack_wdata;
    logic             cmd_wr, xfer_pending, dat0_in, tmo_clr;
    logic [TMO_W-1:0] tmo_cycles;
    logic             cmd_oe, cmd_out, abort_pulse, force_status;
    logic             ack_cfg, boot_ack_ok, data_timeout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    boot_cmd_line_ctrl #(.TMO_W(TMO_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_force_wdata(cfg_force_wdata),
        .cfg_ack_wdata(cfg_ack_wdata), .cmd_wr(cmd_wr), .xfer_pending(xfer_pending),
        .dat0_in(dat0_in), .tmo_cycles(tmo_cycles), .tmo_clr(tmo_clr),
        .cmd_oe(cmd_oe), .cmd_out(cmd_out), .abort_pulse(abort_pulse),
        .force_status(force_status), .ack_cfg(ack_cfg), .boot_ack_ok(boot_ack_ok),
        .data_timeout(data_timeout)
    );

    // Expected outcome of a window: acknowledge iff DAT0 is low on one of N+1 samples.
    function automatic bit exp_ack(int n, int d);
        return d <= n;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic cfg(bit f, bit a);
        cfg_wr = 1'b1; cfg_force_wdata = f; cfg_ack_wdata = a;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic cmd();
        cmd_wr = 1'b1;
        tick();
        cmd_wr = 1'b0;
    endtask

    task automatic clear_tmo();
        tmo_clr = 1'b1;
        tick();
        tmo_clr = 1'b0;
    endtask

    // One acknowledged command with window n; DAT0 falls to be sampled d edges after the first.
    task automatic run_ack(int n, int d);
        dat0_in = 1'b1;
        tmo_cycles = TMO_W'(n);
        cmd();
        for (int i = 0; i <= n + 3; i++) begin
            if (i == d) dat0_in = 1'b0;
            tick();
        end
        chk("R7 ack", boot_ack_ok, exp_ack(n, d));
        chk("R8 timeout", data_timeout, !exp_ack(n, d));
        dat0_in = 1'b1;
        clear_tmo();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst_n = 1'b0; cfg_wr = 0; cfg_force_wdata = 0; cfg_ack_wdata = 0;
        cmd_wr = 0; xfer_pending = 0; dat0_in = 1; tmo_clr = 0; tmo_cycles = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 cmd_oe", cmd_oe, 1'b0);
        chk("R1 cmd_out", cmd_out, 1'b1);
        chk("R1 abort", abort_pulse, 1'b0);
        chk("R1 force_status", force_status, 1'b0);
        chk("R1 ack_cfg", ack_cfg, 1'b0);
        chk("R1 ack_ok", boot_ack_ok, 1'b0);
        chk("R1 timeout", data_timeout, 1'b0);

        // R2 arming alone leaves the line free
        cfg(1'b1, 1'b0);
        repeat (3) tick();
        chk("R2 no drive", cmd_oe, 1'b0);
        // R3 command write activates
        cmd();
        chk("R3 oe", cmd_oe, 1'b1);
        chk("R3 low", cmd_out, 1'b0);
        repeat (4) tick();
        chk("R3 held", cmd_oe, 1'b1);
        // R4 R5 R6 release during a pending transfer
        xfer_pending = 1'b1;
        cfg(1'b0, 1'b0);
        chk("R4 released oe", cmd_oe, 1'b0);
        chk("R4 released out", cmd_out, 1'b1);
        chk("R5 abort", abort_pulse, 1'b1);
        chk("R6 status set", force_status, 1'b1);
        tick();
        chk("R5 single", abort_pulse, 1'b0);
        // R5 clearing an already clear bit: no abort
        cfg(1'b0, 1'b0);
        chk("R5 no abort", abort_pulse, 1'b0);
        chk("R6 status hold", force_status, 1'b1);
        // R6 arm clears status; clear without activation leaves it 0
        cfg(1'b1, 1'b0);
        chk("R6 arm clears", force_status, 1'b0);
        xfer_pending = 1'b0;
        cfg(1'b0, 1'b0);
        chk("R6 never forced", force_status, 1'b0);
        chk("R5 no pending", abort_pulse, 1'b0);
        chk("R4 idle", cmd_oe, 1'b0);

        // R9 acknowledge off: no window
        tmo_cycles = 8'd2;
        cmd();
        repeat (10) tick();
        chk("R9 no timeout", data_timeout, 1'b0);
        chk("R9 no ack", boot_ack_ok, 1'b0);

        // R7 R8 directed window boundaries
        cfg(1'b0, 1'b1);
        chk("R1 ack bit readback", ack_cfg, 1'b1);
        run_ack(0, 0);
        run_ack(0, 1);
        run_ack(5, 5);
        run_ack(5, 6);
        // R8 sticky until cleared
        tmo_cycles = 8'd1;
        cmd();
        repeat (8) tick();
        chk("R8 sticky", data_timeout, 1'b1);
        clear_tmo();
        chk("R8 cleared", data_timeout, 1'b0);
        // R10 new command clears previous acknowledge
        run_ack(3, 1);
        tmo_cycles = 8'd6;
        cmd();
        chk("R10 ack cleared", boot_ack_ok, 1'b0);
        repeat (10) tick();
        clear_tmo();

        // R7 R8 random windows
        for (int k = 0; k < 60; k++) begin
            int n;
            int d;
            n = int'($urandom_range(0, 20));
            d = int'($urandom_range(0, 2 * n + 2));
            run_ack(n, d);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule